// File: doc/BRIEF.md
# Link Status LED Driver

This block turns per-lane link status into active-low LED pin levels for a switch with six links of four differential lanes each, 24 outputs in all. Each lane supplies a synchronized flag and a traffic-enabled flag. From these the block decodes one of three display states for every LED: lit, dark, or blinking. The blinking state marks a lane or link that has achieved synchronization but is not yet allowed to carry traffic.

A strap input is captured while reset is held and fixes the display mode until the next reset. With the strap low, every lane owns one LED. With the strap high, each link shows its status on the lowest LED of its group of four and leaves the other three dark. A free-running blink timer gives all blinking LEDs one common phase with a half-period set in clock cycles. The default is a 500 ms full period at 250 MHz. A per-output enable and value pair lets software drive any pin directly in place of the automatic display.

Top module: `led_status_drv`

## Requirements
- R1: While reset is asserted, and on the first clock edge that samples it, all 24 outputs `led_n` are held at 1 (every LED dark).
- R2: The display mode is the level of `mode_strap` sampled during reset (0 = one LED per lane, 1 = one LED per link). Changes of `mode_strap` after reset is released have no effect on the outputs.
- R3: In per-lane mode, output bit 4*link+lane is driven to 0 one clock after the lane's `lane_sync` and `lane_traffic` are both 1.
- R4: In per-lane mode, an output whose lane has `lane_sync` = 0 is driven to 1, whatever the state of `lane_traffic`.
- R5: An LED in the blinking state (per-lane: sync = 1, traffic = 0) shows the shared blink phase. The phase is 0 (lit) for the first BLINK_HALF clock edges after reset release and then inverts every BLINK_HALF edges. All blinking LEDs show the same level at the same time.
- R6: In per-link mode, bit 4*link is 0 when at least one of that link's four lanes has both sync and traffic set. This holds even if other lanes of the link would otherwise cause a blink.
- R7: In per-link mode, bit 4*link blinks (as in R5) when no lane of the link has both flags set but at least one lane has sync set.
- R8: In per-link mode, bit 4*link is 1 when none of the link's lanes has sync set.
- R9: In per-link mode, bits 4*link+1 to 4*link+3 are held at 1 regardless of the lane flags.
- R10: When `sw_en[i]` is 1, output `led_n[i]` equals `sw_val[i]` one clock later. This applies in either mode, takes priority over the automatic display, and leaves the other bits unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Display-mode strap, captured during reset |
| lane_sync | input | 24 | Per-lane synchronized flag, index 4*link+lane |
| lane_traffic | input | 24 | Per-lane traffic-enabled flag, index 4*link+lane |
| sw_en | input | 24 | Per-output software override enable |
| sw_val | input | 24 | Per-output software override pin level |
| led_n | output | 24 | Active-low LED pins, registered |

## Verification
The hardest case to reach from the ports is a blinking LED seen across a phase inversion while other LEDs are lit, dark, or overridden. A second hard case is a per-link group that mixes an active lane with a merely synchronized one. To reach these, the bench runs with a short blink half-period and holds mixed lane patterns for several half-periods. It predicts the phase from its own count of clock edges since reset release. The strap-capture case is reached by resetting twice with opposite strap levels and then toggling the strap under a pattern that lights different bits in the two modes.

// File: rtl/led_pkg.sv
// Package: shared types for the link status LED driver.
// Assumes: three display states per LED; pin level is active-low.
package led_pkg;

    typedef enum logic [1:0] {
        LED_OFF   = 2'd0,
        LED_ON    = 2'd1,
        LED_BLINK = 2'd2
    } led_state_e;

    // Map a display state and the shared blink phase to an active-low pin level.
    function automatic logic state_to_pin(led_state_e st, logic phase);
        case (st)
            LED_ON:    state_to_pin = 1'b0;
            LED_BLINK: state_to_pin = phase;
            default:   state_to_pin = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/led_mode_latch.sv
// Module: captures the display-mode strap while reset is held.
// Assumes: strap is stable for at least one clock edge inside reset;
// the captured value holds until the next reset.
module led_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    output logic mode_q
);

    // Sample the strap on every edge in reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= strap;
        end
    end

endmodule

// File: rtl/led_blink_gen.sv
// Module: free-running blink timer that gives all blinking LEDs one phase.
// Assumes: HALF_CYC >= 2; phase starts at 0 (lit) on reset release.
module led_blink_gen #(
    parameter int HALF_CYC = 62_500_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);

    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count edges within the half-period and invert the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            phase <= ~phase;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/led_status_decode.sv
// Module: decodes lane flags into a display state for each LED.
// Assumes: lanes of a link are contiguous (index link*LANES+lane); in
// per-link mode only the lowest LED of a group shows status.
module led_status_decode
    import led_pkg::*;
#(
    parameter int LINKS = 6,
    parameter int LANES = 4
) (
    input  logic                   per_link,
    input  logic [LINKS*LANES-1:0] sync,
    input  logic [LINKS*LANES-1:0] traffic,
    output led_state_e             state [LINKS*LANES]
);

    for (genvar lk = 0; lk < LINKS; lk++) begin : g_link
        logic [LANES-1:0] grp_sync;
        logic [LANES-1:0] grp_act;
        led_state_e       link_st;

        assign grp_sync = sync[lk*LANES +: LANES];
        assign grp_act  = sync[lk*LANES +: LANES] & traffic[lk*LANES +: LANES];

        // Aggregate the group: any active lane wins over any synced lane.
        always_comb begin
            if (|grp_act) begin
                link_st = LED_ON;
            end else if (|grp_sync) begin
                link_st = LED_BLINK;
            end else begin
                link_st = LED_OFF;
            end
        end

        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            led_state_e lane_st;

            // Per-lane state from this lane's own flags.
            always_comb begin
                if (grp_act[ln]) begin
                    lane_st = LED_ON;
                end else if (grp_sync[ln]) begin
                    lane_st = LED_BLINK;
                end else begin
                    lane_st = LED_OFF;
                end
            end

            // Choose lane or link view; upper LEDs of a link group stay dark.
            always_comb begin
                if (!per_link) begin
                    state[lk*LANES+ln] = lane_st;
                end else if (ln == 0) begin
                    state[lk*LANES+ln] = link_st;
                end else begin
                    state[lk*LANES+ln] = LED_OFF;
                end
            end
        end
    end

endmodule

// File: rtl/led_out_stage.sv
// Module: applies the software override and registers the pin levels.
// Assumes: sw_val is the pin level itself (0 = lit); reset darkens all LEDs.
module led_out_stage
    import led_pkg::*;
#(
    parameter int N_LED = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  led_state_e       state [N_LED],
    input  logic             phase,
    input  logic [N_LED-1:0] sw_en,
    input  logic [N_LED-1:0] sw_val,
    output logic [N_LED-1:0] led_n
);

    logic [N_LED-1:0] pin_d;

    for (genvar i = 0; i < N_LED; i++) begin : g_pin
        // Override has priority over the decoded display state.
        assign pin_d[i] = sw_en[i] ? sw_val[i] : state_to_pin(state[i], phase);
    end

    // Register the pins; reset turns every LED off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_n <= '1;
        end else begin
            led_n <= pin_d;
        end
    end

endmodule

// File: rtl/led_status_drv.sv
// Module: top of the link status LED driver.
// Assumes: lane flags are synchronous to clk; outputs lag inputs by one clock.
module led_status_drv
    import led_pkg::*;
#(
    parameter int LINKS      = 6,
    parameter int LANES      = 4,
    parameter int BLINK_HALF = 62_500_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mode_strap,
    input  logic [LINKS*LANES-1:0] lane_sync,
    input  logic [LINKS*LANES-1:0] lane_traffic,
    input  logic [LINKS*LANES-1:0] sw_en,
    input  logic [LINKS*LANES-1:0] sw_val,
    output logic [LINKS*LANES-1:0] led_n
);

    localparam int N_LED = LINKS * LANES;

    logic       mode_q;
    logic       blink_ph;
    led_state_e st [N_LED];

    led_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (mode_strap),
        .mode_q (mode_q)
    );

    led_blink_gen #(.HALF_CYC(BLINK_HALF)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_ph)
    );

    led_status_decode #(.LINKS(LINKS), .LANES(LANES)) u_dec (
        .per_link (mode_q),
        .sync     (lane_sync),
        .traffic  (lane_traffic),
        .state    (st)
    );

    led_out_stage #(.N_LED(N_LED)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (st),
        .phase  (blink_ph),
        .sw_en  (sw_en),
        .sw_val (sw_val),
        .led_n  (led_n)
    );

endmodule

// File: rtl/led_status_chk.sv
// Module: assertion checker bound to the LED driver top.
// Assumes: observes ports and the captured mode only.
module led_status_chk #(
    parameter int LINKS = 6,
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mode_q,
    input logic                   mode_strap,
    input logic [LINKS*LANES-1:0] lane_sync,
    input logic [LINKS*LANES-1:0] lane_traffic,
    input logic [LINKS*LANES-1:0] sw_en,
    input logic [LINKS*LANES-1:0] sw_val,
    input logic [LINKS*LANES-1:0] led_n
);

    localparam int N_LED = LINKS * LANES;

    logic [N_LED-1:0] upper_mask;

    // Mark the LEDs that are unused in per-link mode.
    always_comb begin
        upper_mask = '0;
        for (int i = 0; i < N_LED; i++) begin
            upper_mask[i] = ((i % LANES) != 0);
        end
    end

    AST_RESET_DARK: assert property (@(posedge clk)
        !rst_n |=> (led_n == '1)); // R1

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q)); // R2

    AST_MODE_FROM_STRAP: assert property (@(posedge clk)
        !rst_n |=> (mode_q == $past(mode_strap))); // R2

    AST_LANE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_q) |=>
        ((led_n & $past(lane_sync & lane_traffic & ~sw_en)) == '0)); // R3

    AST_LANE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !mode_q) |=>
        ((~led_n & $past(~lane_sync & ~sw_en)) == '0)); // R4

    AST_UPPER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_q) |=>
        ((~led_n & upper_mask & $past(~sw_en)) == '0)); // R9

    AST_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((led_n ^ $past(sw_val)) & $past(sw_en)) == '0)); // R10

endmodule

bind led_status_drv led_status_chk #(.LINKS(LINKS), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_q       (mode_q),
    .mode_strap   (mode_strap),
    .lane_sync    (lane_sync),
    .lane_traffic (lane_traffic),
    .sw_en        (sw_en),
    .sw_val       (sw_val),
    .led_n        (led_n)
);

// File: tb/led_status_drv_test.sv
module led_status_drv_test;

    localparam int LINKS = 6;
    localparam int LANES = 4;
    localparam int N     = LINKS * LANES;
    localparam int HALF  = 8;

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_strap = 1'b0;
    logic [N-1:0] lane_sync = '0;
    logic [N-1:0] lane_traffic = '0;
    logic [N-1:0] sw_en = '0;
    logic [N-1:0] sw_val = '0;
    logic [N-1:0] led_n;

    int    n_checks = 0;
    int    n_fail = 0;
    int    edges = 0;
    logic  bench_mode = 1'b0;
    item_t sb [$];

    led_status_drv #(.LINKS(LINKS), .LANES(LANES), .BLINK_HALF(HALF)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_strap   (mode_strap),
        .lane_sync    (lane_sync),
        .lane_traffic (lane_traffic),
        .sw_en        (sw_en),
        .sw_val       (sw_val),
        .led_n        (led_n)
    );

    always #2 clk = ~clk;

    // Edges since reset release, for the bench's own blink phase.
    always @(posedge clk) begin
        if (rst_n) edges <= edges + 1;
        else       edges <= 0;
    end

    // Expected pins from the requirements.
    function automatic logic [N-1:0] model(logic m, logic [N-1:0] s, logic [N-1:0] t,
                                           logic [N-1:0] e, logic [N-1:0] v, logic ph);
        logic [N-1:0] r;
        r = '1;
        for (int lk = 0; lk < LINKS; lk++) begin
            logic any_act;
            logic any_sync;
            any_act = 1'b0;
            any_sync = 1'b0;
            for (int ln = 0; ln < LANES; ln++) begin
                int i;
                i = lk * LANES + ln;
                any_act  = any_act | (s[i] & t[i]);
                any_sync = any_sync | s[i];
                if (!m) r[i] = (s[i] & t[i]) ? 1'b0 : (s[i] ? ph : 1'b1);
            end
            if (m) r[lk*LANES] = any_act ? 1'b0 : (any_sync ? ph : 1'b1);
        end
        for (int i = 0; i < N; i++) if (e[i]) r[i] = v[i];
        return r;
    endfunction

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic drive(logic [N-1:0] s, logic [N-1:0] t, logic [N-1:0] e,
                         logic [N-1:0] v, string tag);
        item_t it;
        logic  ph;
        @(negedge clk);
        lane_sync = s;
        lane_traffic = t;
        sw_en = e;
        sw_val = v;
        ph = ((edges / HALF) % 2) != 0;
        it.exp = model(bench_mode, s, t, e, v, ph);
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare each result just after the edge that produces it.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (led_n !== it.exp) begin
                n_fail++;
                $display("FAIL %s: led_n=%h expected=%h", it.tag, led_n, it.exp);
            end
        end
    end

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap = strap;
        lane_sync = '1;
        lane_traffic = '1;
        sw_en = '0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (led_n !== '1) begin
            n_fail++;
            $display("FAIL R1: led_n=%h expected=%h", led_n, {N{1'b1}});
        end
        bench_mode = strap;
        lane_sync = '0;
        lane_traffic = '0;
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #400000;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        // Per-lane mode
        do_reset(1'b0);
        drive('0, '0, '0, '0, "R4 idle lanes dark");
        drive('1, '1, '0, '0, "R3 all lanes lit");
        drive(24'h00F0F1, 24'hFFFFFF, '0, '0, "R3 mixed lit lanes");
        drive(24'h000000, 24'hFFFFFF, '0, '0, "R4 traffic without sync dark");
        for (int k = 0; k < 3 * HALF; k++)
            drive(24'h0F00FF, 24'h0F000F, '0, '0, "R5 lane blink phase");
        drive('1, '0, 24'h000003, 24'h000002, "R10 override in lane mode");
        drive('0, '0, 24'h800001, 24'h000000, "R10 override lights dark lanes");

        // Per-link mode
        do_reset(1'b1);
        drive('0, '0, '0, '0, "R8 link dark");
        drive(24'h000002, 24'h000002, '0, '0, "R6 one active lane");
        drive(24'h000006, 24'h000002, '0, '0, "R6 active beats blink");
        drive(24'hFFFFFF, 24'hFFFFFF, '0, '0, "R9 upper bits dark");
        for (int k = 0; k < 3 * HALF; k++)
            drive(24'h840010, 24'h000000, '0, '0, "R7 link blink");
        drive(24'h000008, 24'h000008, 24'h00000E, 24'h000000, "R10 override upper bits");
        @(negedge clk);
        mode_strap = 1'b0;
        drive(24'h000002, 24'h000002, '0, '0, "R2 strap change ignored");
        drive(24'h000400, 24'h000400, '0, '0, "R2 strap change ignored");

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule